// File: doc/BRIEF.md
# Answer-to-Reset Serial Responder

This block answers a synchronous reset pulse from a card reader with a fixed 32-bit identification stream. The reader selects the device by pulling the active-low select input low, raises the reset line for a while, then lowers it. The first bit appears once the reset line falls. After that, every falling edge of the reader's serial clock moves the output on by one bit. The stream is built from four bytes, taken in order from byte 0, with the least significant bit of each byte first. After the last bit it starts again at byte 0, and it keeps going for as long as the reader keeps clocking.

All three reader lines and the busy flag from the nonvolatile write engine are sampled by the system clock. Edges are found from the sampled history. Both the data bit and its output-enable come from registers, so an outside pad cell can turn them into an open-drain or tri-state pin. A reset pulse that arrives while the device is selected also produces a one-cycle abort strobe for the neighbouring two-wire protocol engine. That engine then drops its current transaction and releases the data line. The identification bytes are a parameter fixed at build time. Nothing can change them at run time.

Top module: `atr_serializer`

## Requirements
- R1: In reset, `sda_oe` is 0, `sda_o` is 1 and `xfer_abort` is 0.
- R2: A reset pulse while `cs_n` is high never starts the stream, and `sda_oe` stays 0.
- R3: A reset pulse that rises while `wr_busy` is 1 does not start the stream.
- R4: Once the reset line falls after a valid start, `sda_oe` goes to 1 and `sda_o` carries stream bit 0. With the default bytes that bit is 1.
- R5: Stream bit n is bit (n mod 8) of byte (n div 8), where byte 0 is 19h, byte 1 is 01h, byte 2 is AAh and byte 3 is 55h. Each falling edge of `sclk` advances the output by one bit, and the output does not change between falling edges.
- R6: The falling edge after bit 31 brings back bit 0, and the sequence repeats without end.
- R7: When `cs_n` goes high at any point, `sda_oe` falls to 0 and stays there. Later `sclk` edges leave it at 0.
- R8: Whenever `sda_oe` is 0, `sda_o` is 1.
- R9: A rising edge of `rst_pin` while `cs_n` is low pulses `xfer_abort` for exactly one cycle, whether or not `wr_busy` is set. While `cs_n` is high it does not pulse.
- R10: While the reset line is held high, `sda_oe` stays 0. Any `sclk` edges seen during that time do not move the start point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin | input | 1 | Reader reset line |
| cs_n | input | 1 | Active-low device select |
| sclk | input | 1 | Reader serial clock |
| wr_busy | input | 1 | Nonvolatile write in progress |
| sda_o | output | 1 | Serial data bit (1 when released) |
| sda_oe | output | 1 | Data output enable |
| xfer_abort | output | 1 | One-cycle strobe that ends a two-wire transaction |

## Verification
The assertions rely on the reader lines being slow compared with the system clock. Each level must be held for at least two system cycles, so every edge is seen exactly once and two reset edges never land on adjacent cycles. They also rely on the reset line falling only after it has risen. The stimulus changes each input on the falling system-clock edge and holds every level for four system cycles. It steps through the select, busy and reset orderings one at a time, so these conditions always hold.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2
  } atr_state_e;

  // Positions of the sampled inputs in the edge-detector vector.
  localparam int IN_RST  = 0;
  localparam int IN_CS   = 1;
  localparam int IN_SCLK = 2;
  localparam int IN_BUSY = 3;
  localparam int IN_NUM  = 4;

  localparam int DEF_PAT_BYTES = 4;
  // Byte 0 sits in the low bits, so stream bit n is PATTERN[n].
  localparam logic [31:0] DEF_PATTERN = {8'h55, 8'hAA, 8'h01, 8'h19};
endpackage

// File: rtl/atr_edge_det.sv
module atr_edge_det #(
  parameter int              WIDTH     = 4,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] smp_q;
  logic [WIDTH-1:0] old_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= RESET_VAL;
      old_q <= RESET_VAL;
    end else begin
      smp_q <= raw_i;
      old_q <= smp_q;
    end
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign level_o[g] = smp_q[g];
    assign rise_o[g]  = smp_q[g] & ~old_q[g];
    assign fall_o[g]  = ~smp_q[g] & old_q[g];
  end
endmodule

// File: rtl/atr_pattern_sel.sv
module atr_pattern_sel #(
  parameter int                  PAT_BITS = 32,
  parameter logic [PAT_BITS-1:0] PATTERN  = '0,
  localparam int                 IDX_W    = $clog2(PAT_BITS)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);
  logic [PAT_BITS-1:0] hit;

  for (genvar g = 0; g < PAT_BITS; g++) begin : g_sel
    assign hit[g] = (idx_i == IDX_W'(g)) & PATTERN[g];
  end

  assign bit_o = |hit;
endmodule

// File: rtl/atr_seq_fsm.sv
module atr_seq_fsm
  import atr_pkg::*;
#(
  parameter int PAT_BITS = 32,
  localparam int IDX_W   = $clog2(PAT_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_lvl,
  input  logic             busy_lvl,
  input  logic             rst_rise,
  input  logic             rst_fall,
  input  logic             sclk_fall,
  output logic [IDX_W-1:0] idx_next,
  input  logic             pat_bit,
  output logic             sda_o,
  output logic             sda_oe,
  output logic             xfer_abort
);
  atr_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (rst_rise && !cs_lvl && !busy_lvl) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (cs_lvl || busy_lvl) begin
          state_d = ST_IDLE;
        end else if (rst_fall) begin
          state_d = ST_SEND;
          idx_d   = '0;
        end
      end
      ST_SEND: begin
        if (cs_lvl) begin
          state_d = ST_IDLE;
        end else if (rst_rise) begin
          state_d = ST_ARMED;
        end else if (sclk_fall) begin
          idx_d = (idx_q == IDX_W'(PAT_BITS - 1)) ? '0 : idx_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign idx_next = idx_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      sda_o      <= 1'b1;
      sda_oe     <= 1'b0;
      xfer_abort <= 1'b0;
    end else begin
      state_q    <= state_d;
      idx_q      <= idx_d;
      sda_oe     <= (state_d == ST_SEND);
      sda_o      <= (state_d == ST_SEND) ? pat_bit : 1'b1;
      xfer_abort <= rst_rise && !cs_lvl;
    end
  end
endmodule

// File: rtl/atr_serializer.sv
module atr_serializer
  import atr_pkg::*;
#(
  parameter int                    PAT_BYTES = DEF_PAT_BYTES,
  parameter logic [PAT_BYTES*8-1:0] PATTERN  = DEF_PATTERN
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_pin,
  input  logic cs_n,
  input  logic sclk,
  input  logic wr_busy,
  output logic sda_o,
  output logic sda_oe,
  output logic xfer_abort
);
  localparam int PAT_BITS = PAT_BYTES * 8;
  localparam int IDX_W    = $clog2(PAT_BITS);
  localparam logic [IN_NUM-1:0] IN_IDLE = IN_NUM'(1 << IN_CS);

  logic [IN_NUM-1:0] raw, lvl, rise, fall;
  logic              cs_lvl, busy_lvl, rst_rise_e, rst_fall_e, sclk_fall_e;
  logic [IDX_W-1:0]  idx_next;
  logic              pat_bit;

  always_comb begin
    raw          = '0;
    raw[IN_RST]  = rst_pin;
    raw[IN_CS]   = cs_n;
    raw[IN_SCLK] = sclk;
    raw[IN_BUSY] = wr_busy;
  end

  atr_edge_det #(.WIDTH(IN_NUM), .RESET_VAL(IN_IDLE)) u_edge (
    .clk(clk), .rst(rst), .raw_i(raw),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign cs_lvl      = lvl[IN_CS];
  assign busy_lvl    = lvl[IN_BUSY];
  assign rst_rise_e  = rise[IN_RST];
  assign rst_fall_e  = fall[IN_RST];
  assign sclk_fall_e = fall[IN_SCLK];

  atr_pattern_sel #(.PAT_BITS(PAT_BITS), .PATTERN(PATTERN)) u_pat (
    .idx_i(idx_next), .bit_o(pat_bit)
  );

  atr_seq_fsm #(.PAT_BITS(PAT_BITS)) u_fsm (
    .clk(clk), .rst(rst),
    .cs_lvl(cs_lvl), .busy_lvl(busy_lvl),
    .rst_rise(rst_rise_e), .rst_fall(rst_fall_e), .sclk_fall(sclk_fall_e),
    .idx_next(idx_next), .pat_bit(pat_bit),
    .sda_o(sda_o), .sda_oe(sda_oe), .xfer_abort(xfer_abort)
  );
endmodule

// File: rtl/atr_serializer_chk.sv
module atr_serializer_chk (
  input logic clk,
  input logic rst,
  input logic sda_o,
  input logic sda_oe,
  input logic xfer_abort,
  input logic cs_lvl,
  input logic rst_rise_e,
  input logic rst_fall_e,
  input logic sclk_fall_e
);
  // R8: a released line reads as 1
  p_released_high_r8: assert property (@(posedge clk) disable iff (rst)
    !sda_oe |-> sda_o);

  // R9: the abort strobe lasts a single cycle
  p_abort_single_r9: assert property (@(posedge clk) disable iff (rst)
    xfer_abort |=> !xfer_abort);

  // R4 and R10: the output turns on only right after the reset line falls
  p_start_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(rst_fall_e));

  // R7: a deselected device releases the line on the next cycle
  p_deselect_off_r7: assert property (@(posedge clk) disable iff (rst)
    cs_lvl |=> !sda_oe);

  // R5: no bit change while sending unless the serial clock fell
  p_hold_between_r5: assert property (@(posedge clk) disable iff (rst)
    (sda_oe && $past(sda_oe) && !$past(sclk_fall_e) && !$past(rst_rise_e))
      |-> $stable(sda_o));
endmodule

bind atr_serializer atr_serializer_chk u_chk (
  .clk(clk), .rst(rst), .sda_o(sda_o), .sda_oe(sda_oe),
  .xfer_abort(xfer_abort), .cs_lvl(cs_lvl), .rst_rise_e(rst_rise_e),
  .rst_fall_e(rst_fall_e), .sclk_fall_e(sclk_fall_e)
);

// File: tb/atr_serializer_tb.sv
module atr_serializer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_pin = 1'b0, cs_n = 1'b1, sclk = 1'b0, wr_busy = 1'b0;
  logic sda_o, sda_oe, xfer_abort;

  int checks = 0;
  int fails  = 0;
  int abort_cnt = 0;

  always #2.5 clk = ~clk;

  atr_serializer u_dut (
    .clk(clk), .rst(rst), .rst_pin(rst_pin), .cs_n(cs_n), .sclk(sclk),
    .wr_busy(wr_busy), .sda_o(sda_o), .sda_oe(sda_oe), .xfer_abort(xfer_abort)
  );

  always @(negedge clk) if (!rst && xfer_abort) abort_cnt++;

  function automatic logic exp_bit(int n);
    logic [7:0] b;
    case ((n % 32) / 8)
      0: b = 8'h19;
      1: b = 8'h01;
      2: b = 8'hAA;
      default: b = 8'h55;
    endcase
    return b[n % 8];
  endfunction

  task automatic chk(string req, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, expv);
    end
  endtask

  task automatic chk_int(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1; hold(4);
    sclk = 1'b0; hold(4);
  endtask

  task automatic rst_pulse();
    rst_pin = 1'b1; hold(4);
    rst_pin = 1'b0; hold(4);
  endtask

  task automatic run_stream(int nbits, string req);
    for (int n = 1; n < nbits; n++) begin
      sclk_pulse();
      chk(req, sda_oe, 1'b1);
      chk(req, sda_o, exp_bit(n));
    end
  endtask

  task automatic main_seq();
    int a0;
    hold(3);
    // R1: reset values
    chk("R1", sda_oe, 1'b0);
    chk("R1", sda_o, 1'b1);
    chk("R1", xfer_abort, 1'b0);
    rst = 1'b0;
    hold(4);
    chk("R1", sda_oe, 1'b0);

    // R2: pulse while deselected
    a0 = abort_cnt;
    rst_pulse();
    chk("R2", sda_oe, 1'b0);
    chk_int("R9", abort_cnt, a0);

    // R3: pulse while write busy
    cs_n = 1'b0; wr_busy = 1'b1; hold(4);
    a0 = abort_cnt;
    rst_pulse();
    chk("R3", sda_oe, 1'b0);
    chk_int("R9", abort_cnt, a0 + 1);
    wr_busy = 1'b0; hold(4);

    // R10: hold reset high, clock in between
    a0 = abort_cnt;
    rst_pin = 1'b1; hold(4);
    chk("R10", sda_oe, 1'b0);
    sclk_pulse(); sclk_pulse();
    chk("R10", sda_oe, 1'b0);
    chk_int("R9", abort_cnt, a0 + 1);
    rst_pin = 1'b0; hold(4);
    // R4: first bit after the fall
    chk("R4", sda_oe, 1'b1);
    chk("R4", sda_o, exp_bit(0));
    // R5, R6: over two full passes plus a few bits
    run_stream(70, "R5/R6");

    // R7: deselect mid stream
    cs_n = 1'b1; hold(4);
    chk("R7", sda_oe, 1'b0);
    chk("R8", sda_o, 1'b1);
    sclk_pulse(); sclk_pulse();
    chk("R7", sda_oe, 1'b0);
    chk("R8", sda_o, 1'b1);

    // R4: fresh start after partial stream restarts at bit 0
    cs_n = 1'b0; hold(4);
    rst_pulse();
    chk("R4", sda_o, exp_bit(0));
    run_stream(6, "R5");
    rst_pulse();
    chk("R4", sda_oe, 1'b1);
    chk("R4", sda_o, exp_bit(0));
    run_stream(33, "R6");

    // R7: deselect while armed
    rst_pin = 1'b1; hold(4);
    cs_n = 1'b1; hold(4);
    rst_pin = 1'b0; hold(4);
    chk("R7", sda_oe, 1'b0);
    chk("R8", sda_o, 1'b1);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule